// File: doc/BRIEF.md
# Prediction-Based Read Array Model

This block is a cycle-level behavioural model of a memory bank whose read path senses each column against a predicted bit instead of against ground. A small predictor value, one pixel wide, is loaded now and then and copied across every pixel lane of the word. The result is a full-width prediction pattern that sits on per-column rails. On a read, only those columns whose stored bit differs from the rail bit would pull down one of their two precharged read bit-lines. The model returns the stored word together with a mask of exactly those columns.

Two running counters let an energy study weigh the two costs against each other. One counts the bit-line discharges that reads cause. The other counts the rail bits that flip on each predictor load. Writes use an ordinary port that never involves the prediction rails. The storage is written so that an FPGA flow can map it onto block RAM. Read data appears one clock after the request.

Top module: `pred_read_bank`

## Requirements
- R1: After a synchronous reset, `rd_valid` is 0, both counters read 0 and the prediction pattern is all zeros.
- R2: A write stores the whole `wr_data` word in row `wr_addr`. A later read of that row returns exactly that word. Every row from 0 to ROWS-1 can be addressed.
- R3: `rd_valid` is 1 in the cycle after a cycle with `rd_en` high, and `rd_data` then holds the requested row. In every other cycle `rd_valid` is 0.
- R4: One cycle after `pred_load`, the pattern equals `pred_value` copied into every lane: lane i is bits [8i+7:8i]. Without a load, the pattern holds its value.
- R5: `rd_miss` equals `rd_data` XOR the pattern that was in effect in the request cycle. A load in the same cycle as a read affects only later reads.
- R6: On the clock edge that ends a cycle with `rd_valid` high, `discharge_cnt` rises by the number of ones in `rd_miss`. Otherwise it holds.
- R7: On each load edge, `toggle_cnt` rises by the number of ones in (old pattern XOR new pattern). A load of the value already present adds 0. Without a load, it holds.
- R8: A read and a write to the same row in the same cycle return the row's old contents. The new word is returned by later reads.
- R9: Writes leave the pattern and both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Row to write |
| wr_data | input | WORD_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Row to read |
| pred_load | input | 1 | Load a new predictor |
| pred_value | input | LANE_W | Predictor for one lane |
| rd_valid | output | 1 | Read result present |
| rd_data | output | WORD_W | Word read |
| rd_miss | output | WORD_W | Columns whose bit differs from the prediction |
| pred_pattern | output | WORD_W | Current rail pattern |
| discharge_cnt | output | CNT_W | Accumulated bit-line discharges |
| toggle_cnt | output | CNT_W | Accumulated rail toggles |

## Verification
The assertions check on every cycle that the read result follows the request by one cycle. They also check that the rails and both counters move only when a load or a read result permits, that a load puts the new value in the low lane, and that one read never adds more than the word width to the discharge count. The exact data, mask and counter values can only be shown by the bench's scenarios. These include the sweep over every row with the predictor reloaded each sixteen reads, full-match and full-miss words, and the same-cycle read/write and read/load orderings.

// File: rtl/pred_bank_pkg.sv
package pred_bank_pkg;
  localparam int unsigned PB_LANE_W = 8;
  localparam int unsigned PB_LANES  = 8;
  localparam int unsigned PB_ROWS   = 256;
  localparam int unsigned PB_CNT_W  = 32;
endpackage

// File: rtl/pred_popcount.sv
module pred_popcount #(
  parameter int unsigned W  = 64,
  parameter int unsigned OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [OW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < int'(W); i++) begin
      ones = ones + OW'(vec[i]);
    end
  end
endmodule

// File: rtl/pred_bank_mem.sv
module pred_bank_mem #(
  parameter int unsigned ROWS   = 256,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned ADDR_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_q
);
  logic [WORD_W-1:0] store [ROWS];

  // read-first: a same-cycle write to the read row is seen only later
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (rd_en) rd_q <= store[rd_addr];
  end
endmodule

// File: rtl/pred_rail_reg.sv
module pred_rail_reg #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 8,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned PC_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LANE_W-1:0] value,
  output logic [WORD_W-1:0] pattern,
  output logic [CNT_W-1:0]  toggles
);
  logic [WORD_W-1:0] next_pat;
  logic [PC_W-1:0]   flips;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    assign next_pat[g*LANE_W +: LANE_W] = value;
  end

  pred_popcount #(.W(WORD_W), .OW(PC_W)) u_flip_pc (
    .vec  (pattern ^ next_pat),
    .ones (flips)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pattern <= '0;
      toggles <= '0;
    end else if (load) begin
      pattern <= next_pat;
      toggles <= toggles + CNT_W'(flips);
    end
  end

  // R4
  pat_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> pattern[LANE_W-1:0] == $past(value));
  // R4
  pat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(pattern));
  // R7
  tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(toggles));
  // R7
  tog_bound_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (toggles - $past(toggles)) <= CNT_W'(WORD_W));
endmodule

// File: rtl/pred_sense.sv
module pred_sense #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned PC_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] pattern,
  input  logic [WORD_W-1:0] mem_q,
  output logic              valid,
  output logic [WORD_W-1:0] miss,
  output logic [CNT_W-1:0]  discharges
);
  logic [WORD_W-1:0] pat_at_rd;
  logic [PC_W-1:0]   miss_ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      pat_at_rd <= '0;
    end else begin
      valid <= rd_en;
      if (rd_en) pat_at_rd <= pattern;
    end
  end

  assign miss = mem_q ^ pat_at_rd;

  pred_popcount #(.W(WORD_W), .OW(PC_W)) u_miss_pc (
    .vec  (miss),
    .ones (miss_ones)
  );

  always_ff @(posedge clk) begin
    if (rst)        discharges <= '0;
    else if (valid) discharges <= discharges + CNT_W'(miss_ones);
  end

  // R3
  rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> valid);
  // R3
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !valid);
  // R6
  dis_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(discharges));
  // R6
  dis_bound_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> (discharges - $past(discharges)) <= CNT_W'(WORD_W));
endmodule

// File: rtl/pred_read_bank.sv
module pred_read_bank
  import pred_bank_pkg::*;
#(
  parameter int unsigned ROWS   = PB_ROWS,
  parameter int unsigned LANE_W = PB_LANE_W,
  parameter int unsigned LANES  = PB_LANES,
  parameter int unsigned CNT_W  = PB_CNT_W,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned ADDR_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              pred_load,
  input  logic [LANE_W-1:0] pred_value,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] rd_miss,
  output logic [WORD_W-1:0] pred_pattern,
  output logic [CNT_W-1:0]  discharge_cnt,
  output logic [CNT_W-1:0]  toggle_cnt
);
  pred_bank_mem #(.ROWS(ROWS), .WORD_W(WORD_W)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_q    (rd_data)
  );

  pred_rail_reg #(.LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W)) u_rail (
    .clk     (clk),
    .rst     (rst),
    .load    (pred_load),
    .value   (pred_value),
    .pattern (pred_pattern),
    .toggles (toggle_cnt)
  );

  pred_sense #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_sense (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .pattern    (pred_pattern),
    .mem_q      (rd_data),
    .valid      (rd_valid),
    .miss       (rd_miss),
    .discharges (discharge_cnt)
  );

  // R9
  wr_no_rail_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !pred_load) |=> $stable(pred_pattern));
endmodule

// File: tb/pred_read_bank_tb.sv
module pred_read_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 256;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, pred_load = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0, pred_value = '0;
  logic [W-1:0] wr_data = '0;
  logic rd_valid;
  logic [W-1:0] rd_data, rd_miss, pred_pattern;
  logic [31:0] discharge_cnt, toggle_cnt;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [W-1:0] model [ROWS];
  logic [W-1:0] exp_pat = '0;
  logic [31:0] exp_dis = '0, exp_tog = '0;

  pred_read_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .pred_load(pred_load), .pred_value(pred_value),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_miss(rd_miss),
    .pred_pattern(pred_pattern), .discharge_cnt(discharge_cnt), .toggle_cnt(toggle_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ones(input logic [W-1:0] v);
    logic [31:0] n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [W-1:0] spread(input logic [7:0] v);
    logic [W-1:0] p;
    for (int i = 0; i < 8; i++) p[i*8 +: 8] = v;
    return p;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_pred(input logic [7:0] v);
    @(negedge clk); pred_load = 1'b1; pred_value = v;
    @(negedge clk); pred_load = 1'b0;
    exp_tog = exp_tog + ones(exp_pat ^ spread(v));
    exp_pat = spread(v);
    check("R4 pattern", pred_pattern, exp_pat);
    check("R7 toggles", 64'(toggle_cnt), 64'(exp_tog));
  endtask

  task automatic write_row(input int a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic read_row(input int a);
    @(negedge clk); rd_en = 1'b1; rd_addr = 8'(a);
    @(negedge clk); rd_en = 1'b0;
    check("R3 valid", 64'(rd_valid), 64'd1);
    check("R2 data", rd_data, model[a]);
    check("R5 miss", rd_miss, model[a] ^ exp_pat);
    exp_dis = exp_dis + ones(model[a] ^ exp_pat);
    @(negedge clk);
    check("R6 discharges", 64'(discharge_cnt), 64'(exp_dis));
    check("R3 idle", 64'(rd_valid), 64'd0);
  endtask

  function automatic logic [W-1:0] gen(input int r);
    logic [7:0] base = 8'((r / 16) * 16) ^ 8'h3C;
    if (r % 16 == 1) return spread(base);
    if (r % 16 == 2) return ~spread(base);
    return 64'(r) * 64'h9E37_79B9_7F4A_7C15 ^ spread(base);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", 64'(rd_valid), 64'd0);
    check("R1 discharges", 64'(discharge_cnt), 64'd0);
    check("R1 toggles", 64'(toggle_cnt), 64'd0);
    check("R1 pattern", pred_pattern, 64'd0);

    load_pred(8'hA5);
    load_pred(8'hA5); // R7 same value adds nothing

    for (int r = 0; r < ROWS; r++) write_row(r, gen(r));
    // R9 writes leave rails and counters alone
    check("R9 pattern", pred_pattern, exp_pat);
    check("R9 toggles", 64'(toggle_cnt), 64'(exp_tog));
    check("R9 discharges", 64'(discharge_cnt), 64'(exp_dis));

    for (int r = 0; r < ROWS; r++) begin
      if (r % 16 == 0) load_pred(8'(r) ^ 8'h3C);
      read_row(r);
    end

    // R8 same-row read and write in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd5; wr_data = 64'hDEAD_BEEF_0123_4567;
    rd_en = 1'b1; rd_addr = 8'd5;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R8 old data", rd_data, model[5]);
    exp_dis = exp_dis + ones(model[5] ^ exp_pat);
    model[5] = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    check("R8 discharges", 64'(discharge_cnt), 64'(exp_dis));
    read_row(5);

    // R5 read and load in the same cycle use the old pattern
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'd7; pred_load = 1'b1; pred_value = 8'h0F;
    @(negedge clk); rd_en = 1'b0; pred_load = 1'b0;
    check("R5 miss old pattern", rd_miss, model[7] ^ exp_pat);
    exp_dis = exp_dis + ones(model[7] ^ exp_pat);
    exp_tog = exp_tog + ones(exp_pat ^ spread(8'h0F));
    exp_pat = spread(8'h0F);
    check("R4 pattern after load", pred_pattern, exp_pat);
    check("R7 toggles after load", 64'(toggle_cnt), 64'(exp_tog));
    @(negedge clk);
    check("R6 discharges", 64'(discharge_cnt), 64'(exp_dis));
    read_row(7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule